// File: doc/BRIEF.md
# Ternary Prefix Route Lookup

This block resolves a destination address into a multi-hop routing path for a network interface. It holds a small table of programmable entries. Each entry has a key, a care mask and a valid flag, and each entry is paired with a route word in a separate route store. A care bit set to one takes part in the comparison, and a care bit of zero is a don't-care. Every valid entry is compared with the search address in parallel, which produces one match line per entry.

The selection stage keeps the matching entry whose care mask has the most bits set, so the most specific prefix wins. When two matches have the same length, the lower entry index wins. The winner is a one-hot vector. An encoder turns it into a binary index, and that index addresses the route store. The result (hit flag, winning index and route word) is registered and presented on a valid/ready result port.

Entries are loaded through a plain write port. A write replaces one entry's flag, key, mask and route in a single cycle. The search request is a valid/ready stream. A request is accepted when `srch_valid` and `srch_ready` are both high, and `srch_ready` is high whenever the result slot is empty or being drained in the same cycle. While a result waits with `res_ready` low, the block holds that result unchanged and refuses new requests.

Top module: `route_tcam`

## Requirements
- R1: After reset no entry is valid and `res_valid` is low. A search issued straight after reset reports a miss.
- R2: An address bit whose care bit is zero is left out of the comparison. Any value in that bit still matches.
- R3: An entry whose valid flag is zero never matches, whatever its key and mask hold.
- R4: When several valid entries match, the one with the most care bits set wins.
- R5: When the matching entries tie on care-bit count, the one with the lowest index wins.
- R6: On a hit, `res_idx` is the winning entry and `res_route` is that entry's route word. The route word is six hop codes of three bits each, and hop k sits in bits [3k+2:3k].
- R7: On a miss, `res_hit` is 0, `res_route` is all zeros and `res_idx` is 0.
- R8: A search accepted at a rising edge makes `res_valid` high after that same edge, so the result is seen one cycle after the request.
- R9: While `res_valid` is high and `res_ready` is low, `srch_ready` is low and the result outputs keep their values.
- R10: Entries can be rewritten. A search accepted in the same cycle as a write sees the table as it was before the write.
- R11: A valid entry with an all-zero care mask matches every address and loses to any longer match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | 3 | Entry selected for writing |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_key | input | 32 | Key bits to store |
| cfg_care | input | 32 | Care mask to store (1 = compared) |
| cfg_route | input | 18 | Route word to store (six 3-bit hops) |
| srch_valid | input | 1 | Search request present |
| srch_ready | output | 1 | Search request can be accepted |
| srch_addr | input | 32 | Address to look up |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | At least one valid entry matched |
| res_idx | output | 3 | Winning entry index |
| res_route | output | 18 | Route word of the winning entry |

## Verification
A corrupted key, mask or valid flag shows up at the result port on the first search that touches the damaged entry. It appears as a wrong index, a wrong route or a false hit or miss, one cycle after that search is accepted. A fault in the length comparison or the tie rule only shows when overlapping prefixes match together, so the vectors deliberately stack nested prefixes and duplicate entries. A fault in the result register's hold logic shows within one stalled cycle as a changed route or an asserted `srch_ready`.

// File: rtl/route_tcam_pkg.sv
package route_tcam_pkg;
  localparam int HOP_BITS = 3;
  localparam int HOP_COUNT = 6;

  typedef enum logic [HOP_BITS-1:0] {
    HOP_LOCAL = 3'd0,
    HOP_NORTH = 3'd1,
    HOP_EAST  = 3'd2,
    HOP_SOUTH = 3'd3,
    HOP_WEST  = 3'd4
  } hop_e;
endpackage

// File: rtl/tcam_entry_bank.sv
module tcam_entry_bank #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            wr_valid,
  input  logic [ADDR_W-1:0]               wr_key,
  input  logic [ADDR_W-1:0]               wr_care,
  input  logic [ADDR_W-1:0]               look_addr,
  output logic [ENTRIES-1:0]              match,
  output logic [ENTRIES-1:0][LEN_W-1:0]   plen
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              ent_vld;
    logic [ADDR_W-1:0] ent_key;
    logic [ADDR_W-1:0] ent_care;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld  <= 1'b0;
        ent_key  <= '0;
        ent_care <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_vld  <= wr_valid;
        ent_key  <= wr_key;
        ent_care <= wr_care;
      end
    end

    // A bit mismatches only where the mask asks for a comparison.
    assign match[g] = ent_vld && (((look_addr ^ ent_key) & ent_care) == '0);
    assign plen[g]  = LEN_W'($countones(ent_care));
  end
endmodule

// File: rtl/tcam_prefix_select.sv
module tcam_prefix_select #(
  parameter int ENTRIES = 8,
  parameter int LEN_W   = 6
) (
  input  logic [ENTRIES-1:0]            match,
  input  logic [ENTRIES-1:0][LEN_W-1:0] plen,
  output logic [ENTRIES-1:0]            winner
);
  always_comb begin
    logic             found;
    logic [LEN_W-1:0] best;
    found  = 1'b0;
    best   = '0;
    winner = '0;
    // Ascending scan with strict greater-than keeps the lowest index on ties.
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i] && (!found || plen[i] > best)) begin
        found  = 1'b1;
        best   = plen[i];
        winner = '0;
        winner[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/onehot_to_index.sv
module onehot_to_index #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] onehot,
  output logic         any,
  output logic [W-1:0] index
);
  always_comb begin
    index = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) index = index | W'(i);
    end
  end
  assign any = |onehot;
endmodule

// File: rtl/route_store.sv
module route_store #(
  parameter int DEPTH   = 8,
  parameter int WORD_W  = 18,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/route_tcam.sv
module route_tcam
  import route_tcam_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int HOP_W    = HOP_BITS,
  parameter int HOPS     = HOP_COUNT,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LEN_W   = $clog2(ADDR_W + 1),
  localparam int ROUTE_W = HOP_W * HOPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [ADDR_W-1:0]  cfg_key,
  input  logic [ADDR_W-1:0]  cfg_care,
  input  logic [ROUTE_W-1:0] cfg_route,
  input  logic               srch_valid,
  output logic               srch_ready,
  input  logic [ADDR_W-1:0]  srch_addr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_idx,
  output logic [ROUTE_W-1:0] res_route
);
  logic [ENTRIES-1:0]            match_lines;
  logic [ENTRIES-1:0][LEN_W-1:0] lens;
  logic [ENTRIES-1:0]            win_onehot;
  logic                          win_any;
  logic [IDX_W-1:0]              win_idx;
  logic [ROUTE_W-1:0]            win_route;
  logic                          accept;

  tcam_entry_bank #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_key(cfg_key), .wr_care(cfg_care),
    .look_addr(srch_addr), .match(match_lines), .plen(lens)
  );

  tcam_prefix_select #(.ENTRIES(ENTRIES), .LEN_W(LEN_W)) u_sel (
    .match(match_lines), .plen(lens), .winner(win_onehot)
  );

  onehot_to_index #(.N(ENTRIES)) u_enc (
    .onehot(win_onehot), .any(win_any), .index(win_idx)
  );

  route_store #(.DEPTH(ENTRIES), .WORD_W(ROUTE_W)) u_rt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_data(cfg_route),
    .rd_idx(win_idx), .rd_data(win_route)
  );

  assign srch_ready = !res_valid || res_ready;
  assign accept     = srch_valid && srch_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_route <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_hit   <= win_any;
      res_idx   <= win_any ? win_idx : '0;
      res_route <= win_any ? win_route : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/route_tcam_chk.sv
module route_tcam_chk #(
  parameter int IDX_W   = 3,
  parameter int ROUTE_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_valid,
  input logic               srch_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [ROUTE_W-1:0] res_route
);
  // R8: an accepted request yields a result after that edge
  assert_result_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_ready) |=> res_valid);

  // R8: no request and the slot drains or is empty -> result slot empty next
  assert_no_spurious_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!srch_valid && (!res_valid || res_ready)) |=> !res_valid);

  // R9: a stalled result blocks new requests
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !srch_ready);

  // R9: a stalled result stays put
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit)
      && $stable(res_idx) && $stable(res_route)));

  // R7: a miss carries zero index and route
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_route == '0 && res_idx == '0));
endmodule

bind route_tcam route_tcam_chk #(.IDX_W(IDX_W), .ROUTE_W(ROUTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .srch_valid(srch_valid), .srch_ready(srch_ready),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_hit(res_hit), .res_idx(res_idx), .res_route(res_route)
);

// File: tb/sim_route_tcam.sv
module sim_route_tcam;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_key = '0;
  logic [31:0] cfg_care = '0;
  logic [17:0] cfg_route = '0;
  logic        srch_valid = 1'b0;
  logic        srch_ready;
  logic [31:0] srch_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [2:0]  res_idx;
  logic [17:0] res_route;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  route_tcam u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_key(cfg_key), .cfg_care(cfg_care),
    .cfg_route(cfg_route), .srch_valid(srch_valid), .srch_ready(srch_ready),
    .srch_addr(srch_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_idx(res_idx), .res_route(res_route)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected under 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Route word for entry i: hop h = (i + h) mod 5, hop h in bits [3h+2:3h].
  function automatic logic [17:0] route_of(int i);
    logic [17:0] r = '0;
    for (int h = 0; h < 6; h++) r[3*h +: 3] = 3'((i + h) % 5);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic v, logic [31:0] key, logic [31:0] care);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v;
    cfg_key = key; cfg_care = care; cfg_route = route_of(idx);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Request at a negedge, accepted at the next posedge, result read at the negedge after.
  task automatic look(logic [31:0] a);
    @(negedge clk);
    srch_valid = 1'b1; srch_addr = a;
    @(negedge clk);
    srch_valid = 1'b0;
  endtask

  task automatic expect_res(string req, logic hit, int idx);
    chk(req, {31'd0, res_valid}, 32'd1);
    chk(req, {31'd0, res_hit}, {31'd0, hit});
    chk(req, {29'd0, res_idx}, hit ? 32'(idx) : 32'd0);
    chk(req, {14'd0, res_route}, hit ? {14'd0, route_of(idx)} : 32'd0);
  endtask

  localparam int NV = 8;
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0A01_0203, 32'h0A01_05FF, 32'h0A7F_0000, 32'hC0A8_0101,
    32'hAC10_0001, 32'h0B00_0000, 32'h0A01_02FF, 32'hC0A9_FFFF };
  localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int V_IDX [NV] = '{2, 1, 0, 3, 0, 0, 2, 0};
  localparam string V_REQ [NV] = '{
    "R4 longest /24", "R4 middle /16", "R4 short /8", "R5 tie lowest",
    "R3 invalid entry", "R7 no match", "R2 masked low byte", "R7 near miss" };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
    chk("R1 srch_ready after reset", {31'd0, srch_ready}, 32'd1);
    rst_n = 1'b1;
    look(32'h0A01_0203);
    expect_res("R1 empty table misses", 1'b0, 0);

    wr(0, 1'b1, 32'h0A00_0000, 32'hFF00_0000);
    wr(1, 1'b1, 32'h0A01_0000, 32'hFFFF_0000);
    wr(2, 1'b1, 32'h0A01_0200, 32'hFFFF_FF00);
    wr(3, 1'b1, 32'hC0A8_0000, 32'hFFFF_0000);
    wr(4, 1'b1, 32'hC0A8_0000, 32'hFFFF_0000);
    wr(5, 1'b0, 32'hAC10_0000, 32'hFFF0_0000);

    for (int v = 0; v < NV; v++) begin
      look(V_ADDR[v]);
      expect_res(V_REQ[v], V_HIT[v], V_IDX[v]);
    end

    // R6: hop field position of entry 2, hop 1 = (2+1) mod 5 = 3
    look(32'h0A01_0203);
    chk("R6 hop1 field", {29'd0, res_route[5:3]}, 32'd3);
    chk("R6 hop5 field", {29'd0, res_route[17:15]}, 32'd2);

    // R8: result appears one cycle after acceptance, gone after draining
    @(negedge clk);
    chk("R8 slot empty before request", {31'd0, res_valid}, 32'd0);

    // R9: back-pressure
    @(negedge clk);
    res_ready = 1'b0; srch_valid = 1'b1; srch_addr = 32'hC0A8_0101;
    @(negedge clk);
    srch_addr = 32'h0A01_0203;
    expect_res("R9 stalled result", 1'b1, 3);
    chk("R9 srch_ready low", {31'd0, srch_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    expect_res("R9 held after stall", 1'b1, 3);
    srch_valid = 1'b0; res_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", {31'd0, res_valid}, 32'd0);

    // R10: write and search in the same cycle see the old table
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_valid = 1'b1;
    cfg_key = 32'h0B00_0000; cfg_care = 32'hFF00_0000; cfg_route = route_of(6);
    srch_valid = 1'b1; srch_addr = 32'h0B12_3456;
    @(negedge clk);
    cfg_we = 1'b0; srch_valid = 1'b0;
    expect_res("R10 same-cycle write unseen", 1'b0, 0);
    look(32'h0B12_3456);
    expect_res("R10 write seen later", 1'b1, 6);

    // R11: default entry with empty mask
    wr(7, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000);
    look(32'h1234_5678);
    expect_res("R11 default matches", 1'b1, 7);
    look(32'h0A01_0203);
    expect_res("R11 default loses to prefix", 1'b1, 2);

    // R3: invalidating the longest entry falls back
    wr(2, 1'b0, 32'h0A01_0200, 32'hFFFF_FF00);
    look(32'h0A01_0203);
    expect_res("R3 invalidated entry skipped", 1'b1, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule